// File: doc/BRIEF.md
# Tile Transpose Access Pattern Generator

This block produces the lane address vectors that a group of W parallel lanes needs to transpose a W×W tile held in a W-bank memory. Element (row, col) of the tile sits at address row·W + col, so its bank is the column. The tile is covered in W successive warps. For each warp the block first presents a vector of W read addresses. It then presents the matching vector of W write addresses, so that lane j's read element lands at its transposed position.

Three schedules can be selected at start. The first reads a row and scatters it into a column. The second gathers a column and writes it into a row. The third walks wrapped diagonals on both sides, so that neither the read nor the write puts two lanes on the same bank. Each vector carries a flag that says whether its W addresses fall in W distinct banks under the plain mapping. A downstream checker can compare that flag against the conflicts it observes. Vectors are offered with a valid/ready handshake, and a single-cycle done pulse closes the run.

Top module: `tile_xpose_agen`

## Requirements
- R1: After reset, and until the first accepted start, `vec_valid_o` and `done_o` are 0.
- R2: A start (`start_i`=1 while no run is active, `mode_i` of 0, 1 or 2) makes `vec_valid_o` 1 in the next cycle, with `vec_write_o`=0 and `vec_warp_o`=0.
- R3: A start with `mode_i`=3 is ignored, and the block stays idle. A start during an active run is ignored, and the run continues unchanged with its latched mode.
- R4: For every warp, the read vector (`vec_write_o`=0) comes first and then the write vector (`vec_write_o`=1) of the same warp. After the write vector is accepted (valid and ready high at a clock edge), the warp number rises by 1. While valid is high and ready is low, the vector, the phase and the warp hold.
- R5: Mode 0 (row read, column write): on warp i, lane j reads element (i, j) and writes element (j, i).
- R6: Mode 1 (column read, row write): on warp i, lane j reads element (j, i) and writes element (i, j).
- R7: Mode 2 (diagonal): with d = (i + j) mod W, on warp i lane j reads element (j, d) and writes element (d, j). Both vectors of every warp are conflict-free.
- R8: Lane j's address occupies bits [j·AW +: AW] of `vec_addr_o`, where AW = 2·log2(W). The address of element (r, c) is r·W + c, so its bank is c. `vec_cfree_o` is 1 exactly when the W banks of the presented vector are pairwise distinct.
- R9: `done_o` is high for exactly one cycle: the cycle after the write vector of warp W-1 is accepted. `vec_valid_o` is 0 in that cycle, and a start may be accepted in that same cycle.
- R10: A run accepts exactly 2·W vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a run |
| mode_i | input | 2 | Schedule: 0 row/column, 1 column/row, 2 diagonal, 3 reserved |
| vec_ready_i | input | 1 | Consumer accepts the presented vector |
| vec_valid_o | output | 1 | A vector is presented |
| vec_write_o | output | 1 | 0 for the read vector, 1 for the write vector |
| vec_warp_o | output | log2(W) | Warp number of the presented vector |
| vec_addr_o | output | W·AW | W lane addresses, lane 0 in the low bits |
| vec_cfree_o | output | 1 | Presented vector hits W distinct banks |
| done_o | output | 1 | One-cycle pulse closing a run |

## Verification
The end-of-run pulse and the acceptance of a new start can fall in the same cycle. The next run may begin in the very cycle in which `done_o` is high. The bench provokes this by raising `start_i` as soon as it sees `done_o`, sometimes with a different mode. Its cycle-level reference model then expects the done pulse and, one cycle later, warp 0's read vector in the new mode. A start raised in the middle of a run under stalled ready is also checked: it must change nothing.

// File: rtl/tile_xpose_pkg.sv
package tile_xpose_pkg;

  typedef enum logic [1:0] {
    XM_ROWCOL = 2'd0,
    XM_COLROW = 2'd1,
    XM_DIAG   = 2'd2,
    XM_RSVD   = 2'd3
  } xpose_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } xpose_phase_e;

  function automatic logic mode_usable(input logic [1:0] m);
    return m != XM_RSVD;
  endfunction

endpackage

// File: rtl/tile_xpose_lanemap.sv
module tile_xpose_lanemap
  import tile_xpose_pkg::*;
#(
  parameter int W  = 8,
  localparam int LW = $clog2(W),
  localparam int AW = 2 * LW
) (
  input  xpose_mode_e     mode,
  input  logic            is_write,
  input  logic [LW-1:0]   warp,
  output logic [W*AW-1:0] addr_flat,
  output logic [W*LW-1:0] bank_flat
);

  // Row/column of the element that lane `lane` touches on warp `wi`.
  function automatic logic [AW-1:0] lane_elem(input xpose_mode_e m,
                                              input logic wr,
                                              input logic [LW-1:0] wi,
                                              input logic [LW-1:0] lane);
    logic [LW-1:0] diag;
    logic [LW-1:0] r;
    logic [LW-1:0] c;
    diag = wi + lane;
    unique case (m)
      XM_COLROW: begin r = wr ? wi   : lane; c = wr ? lane : wi;   end
      XM_DIAG:   begin r = wr ? diag : lane; c = wr ? lane : diag; end
      default:   begin r = wr ? lane : wi;   c = wr ? wi   : lane; end
    endcase
    return {r, c};
  endfunction

  for (genvar l = 0; l < W; l++) begin : g_lane
    logic [AW-1:0] elem;
    assign elem = lane_elem(mode, is_write, warp, LW'(l));
    assign addr_flat[l*AW +: AW] = elem;
    assign bank_flat[l*LW +: LW] = elem[LW-1:0];
  end

endmodule

// File: rtl/tile_xpose_bankchk.sv
module tile_xpose_bankchk #(
  parameter int W  = 8,
  localparam int LW = $clog2(W)
) (
  input  logic [W*LW-1:0] bank_flat,
  output logic            distinct
);

  logic [W*W-1:0] clash;

  for (genvar a = 0; a < W; a++) begin : g_a
    for (genvar b = 0; b < W; b++) begin : g_b
      if (b > a) begin : g_pair
        assign clash[a*W+b] = bank_flat[a*LW +: LW] == bank_flat[b*LW +: LW];
      end else begin : g_none
        assign clash[a*W+b] = 1'b0;
      end
    end
  end

  assign distinct = ~|clash;

endmodule

// File: rtl/tile_xpose_seq.sv
module tile_xpose_seq
  import tile_xpose_pkg::*;
#(
  parameter int W  = 8,
  localparam int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic          ready_i,
  output xpose_phase_e  phase,
  output logic [LW-1:0] warp,
  output xpose_mode_e   mode_q,
  output logic          done_q,
  output logic          ev_start,
  output logic          ev_read_acc,
  output logic          ev_write_acc,
  output logic          ev_last
);

  localparam logic [LW-1:0] LAST_WARP = LW'(W - 1);

  assign ev_start     = (phase == PH_IDLE) && start_i && mode_usable(mode_i);
  assign ev_read_acc  = (phase == PH_READ) && ready_i;
  assign ev_write_acc = (phase == PH_WRITE) && ready_i;
  assign ev_last      = ev_write_acc && (warp == LAST_WARP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      warp   <= '0;
      mode_q <= XM_ROWCOL;
      done_q <= 1'b0;
    end else begin
      done_q <= ev_last;
      unique case (phase)
        PH_IDLE: if (ev_start) begin
          phase  <= PH_READ;
          warp   <= '0;
          mode_q <= xpose_mode_e'(mode_i);
        end
        PH_READ: if (ev_read_acc) phase <= PH_WRITE;
        PH_WRITE: if (ev_write_acc) begin
          if (ev_last) begin
            phase <= PH_IDLE;
          end else begin
            phase <= PH_READ;
            warp  <= warp + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tile_xpose_agen.sv
module tile_xpose_agen
  import tile_xpose_pkg::*;
#(
  parameter int W  = 8,
  localparam int LW = $clog2(W),
  localparam int AW = 2 * LW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      mode_i,
  input  logic            vec_ready_i,
  output logic            vec_valid_o,
  output logic            vec_write_o,
  output logic [LW-1:0]   vec_warp_o,
  output logic [W*AW-1:0] vec_addr_o,
  output logic            vec_cfree_o,
  output logic            done_o
);

  xpose_phase_e  phase;
  xpose_mode_e   mode_q;
  logic [LW-1:0] warp;
  logic [W*LW-1:0] bank_flat;
  logic ev_start, ev_read_acc, ev_write_acc, ev_last;

  tile_xpose_seq #(.W(W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .ready_i      (vec_ready_i),
    .phase        (phase),
    .warp         (warp),
    .mode_q       (mode_q),
    .done_q       (done_o),
    .ev_start     (ev_start),
    .ev_read_acc  (ev_read_acc),
    .ev_write_acc (ev_write_acc),
    .ev_last      (ev_last)
  );

  tile_xpose_lanemap #(.W(W)) u_map (
    .mode      (mode_q),
    .is_write  (phase == PH_WRITE),
    .warp      (warp),
    .addr_flat (vec_addr_o),
    .bank_flat (bank_flat)
  );

  tile_xpose_bankchk #(.W(W)) u_bank (
    .bank_flat (bank_flat),
    .distinct  (vec_cfree_o)
  );

  assign vec_valid_o = phase != PH_IDLE;
  assign vec_write_o = phase == PH_WRITE;
  assign vec_warp_o  = warp;

endmodule

// File: rtl/tile_xpose_agen_chk.sv
module tile_xpose_agen_chk
  import tile_xpose_pkg::*;
#(
  parameter int W  = 8,
  localparam int LW = $clog2(W),
  localparam int AW = 2 * LW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [1:0]      mode_i,
  input logic            vec_ready_i,
  input logic            vec_valid_o,
  input logic            vec_write_o,
  input logic [LW-1:0]   vec_warp_o,
  input logic [W*AW-1:0] vec_addr_o,
  input logic            vec_cfree_o,
  input logic            done_o,
  input xpose_mode_e     mode_q,
  input logic            ev_last
);

  // R2: a usable start opens warp 0 with its read vector
  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_valid_o && start_i && mode_i != 2'd3) |=>
      (vec_valid_o && !vec_write_o && vec_warp_o == '0));

  // R3: reserved mode never starts a run
  a_r3_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_valid_o && start_i && mode_i == 2'd3) |=> !vec_valid_o);

  // R3: the latched mode survives a start during a run
  a_r3_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !ev_last) |=> $stable(mode_q));

  // R4: stalled vector holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ready_i) |=>
      (vec_valid_o && $stable(vec_addr_o) && $stable(vec_write_o) && $stable(vec_warp_o)));

  // R4: accepted read is followed by the write of the same warp
  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vec_ready_i && !vec_write_o) |=>
      (vec_valid_o && vec_write_o && $stable(vec_warp_o)));

  // R5: row read side is conflict-free
  a_r5_row_read_free: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_write_o && mode_q == XM_ROWCOL) |-> vec_cfree_o);

  // R6: row write side is conflict-free
  a_r6_row_write_free: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vec_write_o && mode_q == XM_COLROW) |-> vec_cfree_o);

  // R7: diagonal schedule is conflict-free on both sides
  a_r7_diag_free: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && mode_q == XM_DIAG) |-> vec_cfree_o);

  // R9: done follows the last accepted write and lasts one cycle
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vec_ready_i && vec_write_o && vec_warp_o == LW'(W - 1)) |=>
      (done_o && !vec_valid_o));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind tile_xpose_agen tile_xpose_agen_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mode_i      (mode_i),
  .vec_ready_i (vec_ready_i),
  .vec_valid_o (vec_valid_o),
  .vec_write_o (vec_write_o),
  .vec_warp_o  (vec_warp_o),
  .vec_addr_o  (vec_addr_o),
  .vec_cfree_o (vec_cfree_o),
  .done_o      (done_o),
  .mode_q      (mode_q),
  .ev_last     (ev_last)
);

// File: tb/tile_xpose_agen_bench.sv
module tile_xpose_agen_bench;

  localparam int W  = 8;
  localparam int LW = $clog2(W);
  localparam int AW = 2 * LW;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic vec_ready_i = 1'b1;
  logic vec_valid_o, vec_write_o, vec_cfree_o, done_o;
  logic [LW-1:0] vec_warp_o;
  logic [W*AW-1:0] vec_addr_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_xpose_agen #(.W(W)) u_tile_xpose_agen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .vec_ready_i(vec_ready_i), .vec_valid_o(vec_valid_o),
    .vec_write_o(vec_write_o), .vec_warp_o(vec_warp_o),
    .vec_addr_o(vec_addr_o), .vec_cfree_o(vec_cfree_o), .done_o(done_o)
  );

  // Behavioural reference: 0 idle, 1 read vector, 2 write vector
  int m_phase = 0, m_warp = 0, m_mode = 0, m_acc = 0;
  bit m_done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_warp <= 0; m_mode <= 0; m_done <= 0; m_acc <= 0;
    end else begin
      m_done <= 0;
      if (m_phase == 0) begin
        if (start_i && mode_i != 2'd3) begin
          m_phase <= 1; m_warp <= 0; m_mode <= int'(mode_i); m_acc <= 0;
        end
      end else if (vec_ready_i) begin
        m_acc <= m_acc + 1;
        if (m_phase == 1) m_phase <= 2;
        else if (m_warp == W - 1) begin m_phase <= 0; m_done <= 1; end
        else begin m_phase <= 1; m_warp <= m_warp + 1; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic string mode_req(input int m);
    if (m == 0) return "R5";
    if (m == 1) return "R6";
    return "R7";
  endfunction

  // Expected element address for lane j of warp i
  function automatic int exp_addr(input int m, input bit wr, input int i, input int j);
    int r, c;
    int d;
    d = (i + j) % W;
    if (m == 0)      begin r = wr ? j : i; c = wr ? i : j; end
    else if (m == 1) begin r = wr ? i : j; c = wr ? j : i; end
    else             begin r = wr ? d : j; c = wr ? j : d; end
    return r * W + c;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      check(vec_valid_o == (m_phase != 0), "R4 valid", int'(vec_valid_o), int'(m_phase != 0));
      check(done_o == m_done, "R9 done", int'(done_o), int'(m_done));
      if (vec_valid_o && m_phase != 0) begin
        int cnt [W];
        bit free_exp;
        check(vec_write_o == (m_phase == 2), "R4 phase", int'(vec_write_o), int'(m_phase == 2));
        check(int'(vec_warp_o) == m_warp, "R4 warp", int'(vec_warp_o), m_warp);
        foreach (cnt[k]) cnt[k] = 0;
        for (int j = 0; j < W; j++) begin
          int e;
          e = exp_addr(m_mode, m_phase == 2, m_warp, j);
          check(int'(vec_addr_o[j*AW +: AW]) == e, mode_req(m_mode),
                int'(vec_addr_o[j*AW +: AW]), e);
          cnt[e % W]++;
        end
        free_exp = 1;
        foreach (cnt[k]) if (cnt[k] > 1) free_exp = 0;
        check(vec_cfree_o == free_exp, "R8 cfree", int'(vec_cfree_o), int'(free_exp));
      end
    end
  end

  // Called at a falling edge; returns at the falling edge after the start edge.
  task automatic kick(input int m, input bit expect_run);
    start_i = 1'b1;
    mode_i = 2'(m);
    @(negedge clk);
    start_i = 1'b0;
    if (expect_run) begin
      check(vec_valid_o && !vec_write_o && vec_warp_o == '0, "R2 start",
            int'(vec_valid_o), 1);
    end
  endtask

  task automatic drain(input bit throttle, input bit poke_mid);
    int n = 0;
    while (!done_o && n < 5000) begin
      vec_ready_i = throttle ? (($urandom % 3) != 0) : 1'b1;
      if (poke_mid && n == 5) begin
        start_i = 1'b1; mode_i = 2'd2;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      if (poke_mid && n == 5) check(vec_valid_o == 1'b1, "R3 busy start", int'(vec_valid_o), 1);
      n++;
    end
    start_i = 1'b0;
    vec_ready_i = 1'b1;
    check(done_o == 1'b1, "R9 reached done", int'(done_o), 1);
    check(vec_valid_o == 1'b0, "R9 idle at done", int'(vec_valid_o), 0);
    check(m_acc == 2 * W, "R10 vector count", m_acc, 2 * W);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(vec_valid_o == 1'b0, "R1 valid in reset", int'(vec_valid_o), 0);
    check(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vec_valid_o == 1'b0 && done_o == 1'b0, "R1 idle after reset", int'(vec_valid_o), 0);

    kick(0, 1); drain(0, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R9 single pulse", int'(done_o), 0);
    kick(1, 1); drain(1, 0);
    @(negedge clk);
    kick(2, 1); drain(1, 0);

    // start coinciding with the done pulse, changing mode
    kick(1, 1); drain(0, 0);
    kick(2, 1); drain(1, 0);

    // reserved mode ignored
    @(negedge clk);
    kick(3, 0);
    for (int k = 0; k < 3; k++) begin
      check(vec_valid_o == 1'b0, "R3 reserved mode", int'(vec_valid_o), 0);
      @(negedge clk);
    end

    // start during a stalled run is ignored
    kick(0, 1); drain(1, 1);
    kick(2, 1); drain(0, 1);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule